// File: doc/BRIEF.md
# Corrected Sample Acquisition Channel

This block serves one converter channel. Each strobed 16-bit sample arrives in offset-binary form. The block adds a programmable signed offset to it, then scales the result by a programmable unsigned fixed-point gain. It clamps the result to the 16-bit range and pushes it into a 2050-entry first-in first-out store. Software drains the store through a data register. Each read of that register returns the oldest stored sample and removes it.

Status flags report three conditions: the store is empty, the store is at least half full, and a sample was lost because the store was full. Separate enables route the half-full and lost-sample conditions to one interrupt line. Calibration values enter through the same single-cycle register port. A chip instantiates one copy of this block per channel.

The register port is run by a two-state machine. In `RP_IDLE` the port waits. The `accept` transition fires when a read is requested in `RP_IDLE`: it captures the address, pops the store if the address is the data register, and moves to `RP_RESP`. `RP_RESP` presents the read data with a valid strobe for one cycle. The `respond` transition then returns to `RP_IDLE` unconditionally. Writes are taken in either state. Samples reach the store two clock edges after their strobe and are written on the third.

Top module: `acq_chan`

## Requirements
- R1: After reset, the store reads empty (status bit 0 = 1), half-full (bit 1) and overflow (bit 2) read 0, gain reads 0x10000, offset reads 0, and the interrupt is low.
- R2: With gain 0x10000 and offset 0, every sample is stored unchanged.
- R3: The offset register (address 2, bits 15:0, two's complement) is added to the sample's signed value (the sample minus 0x8000) before any scaling.
- R4: The sum is multiplied by the gain register (address 1, bits 16:0, unsigned, 16 fractional bits), and the product is shifted right by 16 with rounding toward minus infinity.
- R5: A scaled result outside the signed 16-bit range is clamped, and the stored value is that result plus 0x8000 in offset binary (0xFFFF highest, 0x0000 lowest).
- R6: A read of address 0 returns the oldest stored sample in bits 15:0, in arrival order, and removes it.
- R7: The store holds 2050 samples. Status bit 1 is set exactly when at least 1024 samples are held.
- R8: A sample that arrives while the store holds 2050 is dropped and sets status bit 2. That bit stays set until a status write (address 3) with bit 2 = 1. A write with bit 2 = 0 leaves it set. If a set and a clear happen in the same cycle, the set wins.
- R9: A read of address 0 on an empty store returns the last sample removed (0 if none has been) and changes neither the contents nor the flags.
- R10: The interrupt is high when status bit 1 is set and enable bit 0 of address 4 is set, or when status bit 2 is set and enable bit 1 of address 4 is set.
- R11: Read data appears on the cycle after the read request, with a valid strobe lasting exactly one cycle. Requests made while that response is shown are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Raw offset-binary sample |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 17 | Register write data |
| reg_rdata | output | 17 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks saturation at both ends of the range. A design that wrapped instead of clamping would turn a maximum reading into a near-minimum one. It checks that the offset is added before the multiply: a design that scaled first would give values that drift with the gain. It checks the half-full threshold at 1023 and at 1024 samples, which catches an off-by-one comparison. At full capacity it pushes one extra sample and then drains the whole store. A design that overwrote stored data would return the extra sample or lose the order. It also checks that writing 0 does not clear the overflow flag, and that reading an empty store neither moves the pointers nor changes the returned value.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int SMP_W   = 16;
    localparam int GAIN_W  = 17;
    localparam int GAIN_FR = 16;
    localparam int STORE_D = 2050;
    localparam int HALF_TH = 1024;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA   = 3'd0,
        A_GAIN   = 3'd1,
        A_OFFSET = 3'd2,
        A_STATUS = 3'd3,
        A_IRQEN  = 3'd4
    } reg_addr_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } port_state_e;
endpackage

// File: rtl/acq_corr.sv
module acq_corr #(
    parameter int DW = 16,
    parameter int GW = 17,
    parameter int FR = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    input  logic [DW-1:0]        offset,
    input  logic [GW-1:0]        gain,
    output logic                 out_valid,
    output logic [DW-1:0]        out_data
);
    localparam int SW = DW + 1;
    localparam int PW = SW + GW + 1;
    localparam int RW = PW - FR;

    logic signed [SW-1:0] sum_q;
    logic                 v1_q;
    logic signed [SW-1:0] centred;
    logic signed [PW-1:0] prod;
    logic signed [RW-1:0] scaled;
    logic signed [DW-1:0] clamped;

    always_comb begin
        centred = SW'(signed'({~in_data[DW-1], in_data[DW-2:0]}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            v1_q  <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) sum_q <= centred + SW'(signed'(offset));
        end
    end

    always_comb begin
        prod   = PW'(sum_q) * PW'(signed'({1'b0, gain}));
        scaled = RW'(prod >>> FR);
        if (scaled > RW'(signed'((1 << (DW-1)) - 1)))
            clamped = DW'((1 << (DW-1)) - 1);
        else if (scaled < -RW'(signed'(1 << (DW-1))))
            clamped = {1'b1, {(DW-1){1'b0}}};
        else
            clamped = DW'(scaled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) out_data <= {~clamped[DW-1], clamped[DW-2:0]};
        end
    end

    // R2
    pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 2050,
    parameter int HALF  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          ovf_clr,
    output logic [DW-1:0] rd_q,
    output logic          empty,
    output logic          half,
    output logic          full,
    output logic          ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
    logic [CNT_W-1:0] cnt;
    logic             do_wr, do_rd;

    generate
        if (DEPTH == (1 << PTR_W)) begin : g_pow2
            assign wp_nx = wp + 1'b1;
            assign rp_nx = rp + 1'b1;
        end else begin : g_wrap
            assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign half  = (cnt >= CNT_W'(HALF));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            rd_q <= '0;
            ovf  <= 1'b0;
        end else begin
            if (do_wr) wp <= wp_nx;
            if (do_rd) begin
                rp   <= rp_nx;
                rd_q <= mem[rp];
            end
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (wr_en && full) ovf <= 1'b1;
            else if (ovf_clr)  ovf <= 1'b0;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(wr_en && full));
    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(cnt));
    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> ($stable(rd_q) && $stable(rp)));
endmodule

// File: rtl/acq_regs.sv
module acq_regs
    import acq_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 17,
    parameter int FR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [GW-1:0]     reg_wdata,
    input  logic [DW-1:0]     fifo_q,
    input  logic              st_empty,
    input  logic              st_half,
    input  logic              st_ovf,
    output logic              pop,
    output logic              ovf_clr,
    output logic [GW-1:0]     gain,
    output logic [DW-1:0]     offset,
    output logic [1:0]        irq_en,
    output logic [GW-1:0]     reg_rdata,
    output logic              reg_rvalid
);
    port_state_e     state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic            accept;

    assign accept  = reg_rd && (state == RP_IDLE);
    assign pop     = accept && (reg_addr == A_DATA);
    assign ovf_clr = reg_wr && (reg_addr == A_STATUS) && reg_wdata[2];

    always_comb begin
        state_nx = state;
        unique case (state)
            RP_IDLE: if (reg_rd) state_nx = RP_RESP;
            RP_RESP: state_nx = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RP_IDLE;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) addr_q <= reg_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain   <= GW'(1 << FR);
            offset <= '0;
            irq_en <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_GAIN:   gain   <= reg_wdata;
                A_OFFSET: offset <= reg_wdata[DW-1:0];
                A_IRQEN:  irq_en <= reg_wdata[1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rvalid = 1'b0;
        reg_rdata  = '0;
        unique case (state)
            RP_IDLE: ;
            RP_RESP: begin
                reg_rvalid = 1'b1;
                unique case (addr_q)
                    A_DATA:   reg_rdata = GW'(fifo_q);
                    A_GAIN:   reg_rdata = gain;
                    A_OFFSET: reg_rdata = GW'(offset);
                    A_STATUS: reg_rdata = GW'({st_ovf, st_half, st_empty});
                    A_IRQEN:  reg_rdata = GW'(irq_en);
                    default:  reg_rdata = '0;
                endcase
            end
        endcase
    end

    // R11
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_rd));
    // R11
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |=> !reg_rvalid);
endmodule

// File: rtl/acq_chan.sv
module acq_chan
    import acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [GAIN_W-1:0] reg_wdata,
    output logic [GAIN_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq
);
    logic              c_valid;
    logic [SMP_W-1:0]  c_data;
    logic [SMP_W-1:0]  fifo_q;
    logic              st_empty, st_half, st_full, st_ovf;
    logic              pop, ovf_clr;
    logic [GAIN_W-1:0] gain;
    logic [SMP_W-1:0]  offset;
    logic [1:0]        irq_en;

    acq_corr #(.DW(SMP_W), .GW(GAIN_W), .FR(GAIN_FR)) u_corr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(smp_valid), .in_data(smp_data),
        .offset(offset), .gain(gain),
        .out_valid(c_valid), .out_data(c_data)
    );

    acq_fifo #(.DW(SMP_W), .DEPTH(STORE_D), .HALF(HALF_TH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(c_valid), .wr_data(c_data),
        .rd_en(pop), .ovf_clr(ovf_clr),
        .rd_q(fifo_q), .empty(st_empty), .half(st_half),
        .full(st_full), .ovf(st_ovf)
    );

    acq_regs #(.DW(SMP_W), .GW(GAIN_W), .FR(GAIN_FR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fifo_q(fifo_q),
        .st_empty(st_empty), .st_half(st_half), .st_ovf(st_ovf),
        .pop(pop), .ovf_clr(ovf_clr), .gain(gain), .offset(offset),
        .irq_en(irq_en), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    assign irq = (st_half && irq_en[0]) || (st_ovf && irq_en[1]);

    // R8
    full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> (st_half && !st_empty));
endmodule

// File: tb/tb_acq_chan.sv
module tb_acq_chan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [16:0] reg_wdata = '0;
    logic [16:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] expq[$];
    logic [15:0] cur_off  = 16'h0000;
    logic [16:0] cur_gain = 17'h10000;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_chan dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq(irq)
    );

    function automatic logic [15:0] model(logic [15:0] raw, logic [15:0] off,
                                          logic [16:0] g);
        longint s, p;
        s = longint'(raw) - 64'sd32768 + longint'($signed(off));
        p = (s * longint'(g)) >>> 16;
        if (p > 32767)  p = 32767;
        if (p < -32768) p = -32768;
        return 16'(p + 32768);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [16:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 3'd1) cur_gain = d;
        if (a == 3'd2) cur_off  = d[15:0];
    endtask

    task automatic rd(logic [2:0] a, output logic [16:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        if (reg_rvalid !== 1'b1) begin
            checks++; fails++;
            $display("FAIL R11: actual rvalid %b expected 1", reg_rvalid);
        end
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic push(logic [15:0] raw);
        smp_valid = 1'b1; smp_data = raw;
        @(negedge clk);
        smp_valid = 1'b0;
        expq.push_back(model(raw, cur_off, cur_gain));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drain_check(string tag);
        logic [16:0] d;
        while (expq.size() > 0) begin
            logic [15:0] e;
            e = expq.pop_front();
            rd(3'd0, d);
            chk(tag, 32'(d), 32'(e));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [16:0] d;
        logic [15:0] lastv;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        rd(3'd3, d); chk("R1 status", 32'(d), 32'h1);
        rd(3'd1, d); chk("R1 gain", 32'(d), 32'h10000);
        rd(3'd2, d); chk("R1 offset", 32'(d), 32'h0);
        // R9 empty read before any pop returns 0
        rd(3'd0, d); chk("R9 empty first", 32'(d), 32'h0);

        // R2 pass-through with random samples and extremes
        push(16'h0000); push(16'hFFFF); push(16'h8000);
        for (int i = 0; i < 20; i++) push(16'($urandom));
        settle();
        drain_check("R2 passthrough");

        // R11 readback of calibration registers
        wr(3'd1, 17'h0C000); wr(3'd2, 16'hFF00);
        rd(3'd1, d); chk("R11 gain readback", 32'(d), 32'h0C000);
        rd(3'd2, d); chk("R11 offset readback", 32'(d), 32'hFF00);

        // R3 R4 offset added before scaling: raw 0x9000 -> 4096, -256 -> 3840 * 0.75 = 2880
        push(16'h9000);
        settle();
        rd(3'd0, d); chk("R3 offset-then-gain", 32'(d), 32'(16'h8000 + 16'd2880));
        void'(expq.pop_front());

        // R4 floor rounding on negative value: raw 0x7FFF -> -1, off 0, gain 0.5 -> -1
        wr(3'd2, 17'h0); wr(3'd1, 17'h08000);
        push(16'h7FFF);
        settle();
        rd(3'd0, d); chk("R4 floor", 32'(d), 32'h7FFF);
        void'(expq.pop_front());

        // R3 R4 random calibration sets
        for (int k = 0; k < 6; k++) begin
            wr(3'd1, 17'($urandom));
            wr(3'd2, 17'($urandom) & 17'h0FFFF);
            for (int i = 0; i < 12; i++) push(16'($urandom));
            settle();
            drain_check("R4 random gain/offset");
        end

        // R5 saturation at both ends
        wr(3'd1, 17'h10000); wr(3'd2, 17'h07FFF);
        push(16'hFFFF); push(16'hC000);
        wr(3'd2, 17'h08000);
        push(16'h0000); push(16'h4000);
        wr(3'd2, 17'h0); wr(3'd1, 17'h1FFFF);
        push(16'hF000); push(16'h1000);
        settle();
        rd(3'd0, d); chk("R5 top clamp", 32'(d), 32'hFFFF);
        rd(3'd0, d); chk("R5 top clamp b", 32'(d), 32'hFFFF);
        rd(3'd0, d); chk("R5 bottom clamp", 32'(d), 32'h0000);
        rd(3'd0, d); chk("R5 bottom clamp b", 32'(d), 32'h0000);
        rd(3'd0, d); chk("R5 gain clamp hi", 32'(d), 32'hFFFF);
        rd(3'd0, d); chk("R5 gain clamp lo", 32'(d), 32'h0000);
        lastv = 16'h0000;
        expq.delete();

        // R9 empty read returns last value and leaves state alone
        rd(3'd0, d); chk("R9 empty repeat", 32'(d), 32'(lastv));
        rd(3'd0, d); chk("R9 empty repeat b", 32'(d), 32'(lastv));
        rd(3'd3, d); chk("R9 still empty", 32'(d), 32'h1);

        // R7 R10 fill and half-full threshold
        wr(3'd1, 17'h10000); wr(3'd2, 17'h0);
        wr(3'd4, 17'h1);
        for (int i = 0; i < 1023; i++) push(16'($urandom));
        settle();
        rd(3'd3, d); chk("R7 1023 not half", 32'(d), 32'h0);
        chk("R10 irq low below half", 32'(irq), 32'd0);
        push(16'h1234);
        settle();
        rd(3'd3, d); chk("R7 1024 half", 32'(d), 32'h2);
        chk("R10 irq half", 32'(irq), 32'd1);
        wr(3'd4, 17'h0);
        chk("R10 irq masked", 32'(irq), 32'd0);
        for (int i = 0; i < 1026; i++) push(16'($urandom));
        settle();
        rd(3'd3, d); chk("R7 full no ovf", 32'(d), 32'h2);

        // R8 overflow: dropped sample, sticky flag, W1C
        push(16'hABCD);
        void'(expq.pop_back());
        settle();
        rd(3'd3, d); chk("R8 ovf set", 32'(d), 32'h6);
        wr(3'd4, 17'h2);
        chk("R10 irq ovf", 32'(irq), 32'd1);
        wr(3'd3, 17'h3);
        rd(3'd3, d); chk("R8 write 0 keeps", 32'(d), 32'h6);
        wr(3'd3, 17'h4);
        rd(3'd3, d); chk("R8 W1C clears", 32'(d), 32'h2);
        chk("R10 irq after clear", 32'(irq), 32'd0);
        chk("R7 depth", 32'(expq.size()), 32'd2050);
        drain_check("R6 order after fill");
        rd(3'd3, d); chk("R6 drained empty", 32'(d), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule